// File: doc/BRIEF.md
# Partially Decoded Mirrored Memory Map

This block is the memory side of an 8-bit processor bus with a 16-bit address, a memory/I-O cycle qualifier, active-low read and write strobes, and separate 8-bit write-data and read-data ports, so no tristate is needed. The two top address bits and the next three address bits feed a pair of 3-to-8 decoders. Each decoder drives the chip select of one internal RAM array.

The first array holds 2 KB and is fully decoded. It answers only at 8800h–8FFFh. The second array holds 256 bytes and is decoded on purpose with three address bits left unused. Those bits (A10–A8) are don't-care, so the same 256 bytes appear eight times across 2000h–27FFh. The range 2000h–20FFh is the primary copy, and 2100h–27FFh are its mirrors. A host can write through any mirror and read the byte back through any other.

Reads are combinational from the addressed location and are gated by the read strobe. Writes are taken on the rising clock edge. The chip-select lines are brought out so that the address decode can be observed.

Top module: `mirror_memmap`

## Requirements
- R1: Chip-select bit 0 (the 2 KB array) is high exactly when the cycle is a memory cycle (`io_sel_i` = 0) and A15–A11 = 10001b, i.e. addresses 8800h–8FFFh. That array is indexed by A10–A0.
- R2: Chip-select bit 1 (the 256-byte array) is high exactly when the cycle is a memory cycle and A15–A11 = 00100b, i.e. 2000h–27FFh, whatever the value of A10–A8. That array is indexed by A7–A0.
- R3: On a rising clock edge with `wr_n_i` = 0, reset released and a chip select high, `wdata_i` is stored at the addressed location of the selected array. Distinct indexes hold distinct bytes.
- R4: A byte written at 2000h + k·100h + n (k in 0..7, n in 0..FFh) reads back at 2000h + m·100h + n for every m in 0..7.
- R5: When `rd_n_i` = 0 and a chip select is high, `rvalid_o` = 1 and `rdata_o` carries the addressed byte in the same cycle. Otherwise `rvalid_o` = 0 and `rdata_o` = 00h.
- R6: When `io_sel_i` = 1, both chip selects are low, `rvalid_o` = 0, and no write takes effect.
- R7: Every address outside 8800h–8FFFh and 2000h–27FFh selects nothing and writes nothing. In particular, 0000h–07FFh, 0800h–0FFFh, 2800h–2FFFh, 8000h–87FFh and 9000h–FFFFh do not alias into either array.
- R8: The chip-select vector is one-hot or all zero.
- R9: While `rst_n` = 0, write strobes have no effect on the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; writes are taken on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; blocks writes while low |
| addr_i | input | 16 | Bus address A15–A0 |
| io_sel_i | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_n_i | input | 1 | Active-low read strobe |
| wr_n_i | input | 1 | Active-low write strobe |
| wdata_i | input | 8 | Write data from the processor |
| rdata_o | output | 8 | Read data; 00h when not valid |
| rvalid_o | output | 1 | Read data valid |
| csel_o | output | 2 | Chip selects: bit 0 = 2 KB array, bit 1 = 256-byte array |

## Verification
On every cycle the assertions check the decode rules: the address window of each chip select, silence during I/O cycles, the one-hot property of the selects, and the gating of the read-valid flag and read data by the read strobe. A further property checks that a write into the small array is visible at the same low byte in the next cycle, whatever the mirror bits are. The other behaviours can be shown only by the bench's scenarios. These are that data written through one mirror reads back through the primary and the other mirrors, that writes to neighbouring unmapped windows do not disturb the 2 KB array, that I/O cycles and writes during reset leave stored bytes unchanged, and that distinct indexes keep distinct data.

// File: rtl/mm_pkg.sv
// Package: shared bus widths and decode constants for the mirrored memory map.
// Assumes a 16-bit address with a 2-bit enable field and a 3-bit select field.
package mm_pkg;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int HI_W     = 2;                  // enable field width
    localparam int SEL_W    = 3;                  // decoder input width
    localparam int HI_LSB   = ADDR_W - HI_W;      // A14
    localparam int SEL_LSB  = HI_LSB - SEL_W;     // A11
    localparam int N_REGION = 2;                  // number of RAM arrays

    // decode key for one region: enable field value and decoder output index
    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [SEL_W-1:0] out_idx;
    } region_key_t;
endpackage

// File: rtl/mm_dec3to8.sv
// Module: enabled binary-to-one-hot decoder (3-to-8 by default).
// Assumes the enable already folds in the memory-cycle and top-bit match.
module mm_dec3to8 #(
    parameter int N_IN = 3
) (
    input  logic                 en_i,
    input  logic [N_IN-1:0]      sel_i,
    output logic [(1<<N_IN)-1:0] out_o
);
    localparam int N_OUT = 1 << N_IN;

    // one output line per select code, all low when disabled
    for (genvar g = 0; g < N_OUT; g++) begin : g_line
        assign out_o[g] = en_i && (sel_i == N_IN'(g));
    end
endmodule

// File: rtl/mm_ram.sv
// Module: single-port RAM with a synchronous write and a combinational read.
// Assumes the caller gates we_i with chip select, strobe and reset; no reset of contents.
module mm_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // store the write data at the addressed word
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[addr_i] <= wdata_i;
        end
    end

    // present the addressed word
    assign rdata_o = mem[addr_i];
endmodule

// File: rtl/mirror_memmap.sv
// Module: memory map with one fully decoded 2 KB array and one 256-byte array
// that appears eight times because A10-A8 do not enter its decode.
// Assumes a single synchronous bus clock and strobes that are stable around its edge.
module mirror_memmap
    import mm_pkg::*;
#(
    parameter int          BIG_AW    = 11,
    parameter int          SMALL_AW  = 8,
    parameter region_key_t BIG_KEY   = '{hi: 2'b10, out_idx: 3'd1},
    parameter region_key_t SMALL_KEY = '{hi: 2'b00, out_idx: 3'd4}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              io_sel_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic [N_REGION-1:0] csel_o
);
    localparam int N_LINES = 1 << SEL_W;

    region_key_t key [N_REGION];
    assign key[0] = BIG_KEY;
    assign key[1] = SMALL_KEY;

    logic                    mem_cycle;
    logic [HI_W-1:0]         hi_field;
    logic [SEL_W-1:0]        sel_field;
    logic [N_LINES-1:0]      dec_lines [N_REGION];
    logic [N_REGION-1:0]     cs;
    logic [N_REGION-1:0]     we;
    logic [DATA_W-1:0]       arr_rdata [N_REGION];

    // split the address into the decode fields
    assign mem_cycle = !io_sel_i;
    assign hi_field  = addr_i[ADDR_W-1 -: HI_W];
    assign sel_field = addr_i[HI_LSB-1 -: SEL_W];

    // one decoder per region, each enabled by its own top-bit pattern
    for (genvar r = 0; r < N_REGION; r++) begin : g_region
        mm_dec3to8 #(.N_IN(SEL_W)) u_dec (
            .en_i  (mem_cycle && (hi_field == key[r].hi)),
            .sel_i (sel_field),
            .out_o (dec_lines[r])
        );
        assign cs[r] = dec_lines[r][key[r].out_idx];
        assign we[r] = cs[r] && !wr_n_i && rst_n;
    end

    // 2 KB array: fully decoded, indexed by the low BIG_AW bits
    mm_ram #(.AW(BIG_AW), .DW(DATA_W)) u_big (
        .clk     (clk),
        .we_i    (we[0]),
        .addr_i  (addr_i[BIG_AW-1:0]),
        .wdata_i (wdata_i),
        .rdata_o (arr_rdata[0])
    );

    // 256-byte array: the bits between SMALL_AW and SEL_LSB are never looked at
    mm_ram #(.AW(SMALL_AW), .DW(DATA_W)) u_small (
        .clk     (clk),
        .we_i    (we[1]),
        .addr_i  (addr_i[SMALL_AW-1:0]),
        .wdata_i (wdata_i),
        .rdata_o (arr_rdata[1])
    );

    // steer the selected array onto the read port, zero when idle
    always_comb begin
        rdata_o  = '0;
        rvalid_o = 1'b0;
        for (int r = 0; r < N_REGION; r++) begin
            if (cs[r] && !rd_n_i) begin
                rdata_o  = arr_rdata[r];
                rvalid_o = 1'b1;
            end
        end
    end

    assign csel_o = cs;
endmodule

// File: rtl/mm_checker.sv
// Module: cycle-by-cycle property checks for mirror_memmap, attached by bind.
// Assumes the default decode keys (2 KB at 10001b, 256 B at 00100b in A15-A11).
module mm_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] addr_i,
    input logic        io_sel_i,
    input logic        rd_n_i,
    input logic        wr_n_i,
    input logic [7:0]  wdata_i,
    input logic [7:0]  rdata_o,
    input logic        rvalid_o,
    input logic [1:0]  csel_o
);
    assert_big_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        csel_o[0] |-> (addr_i[15:11] == 5'b10001 && !io_sel_i));

    assert_small_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        csel_o[1] |-> (addr_i[15:11] == 5'b00100 && !io_sel_i));

    // R4: a write through any mirror is seen next cycle through any other mirror
    assert_mirror_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (csel_o[1] && !wr_n_i) |=>
        (!( !rd_n_i && csel_o[1] && addr_i[7:0] == $past(addr_i[7:0]))
         || rdata_o == $past(wdata_i)));

    assert_valid_gating_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> (!rd_n_i && csel_o != 2'b00));

    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid_o |-> (rdata_o == 8'h00));

    assert_io_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        io_sel_i |-> (csel_o == 2'b00 && !rvalid_o));

    assert_unmapped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i[15:11] != 5'b10001 && addr_i[15:11] != 5'b00100) |-> (csel_o == 2'b00));

    assert_cs_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(csel_o));
endmodule

bind mirror_memmap mm_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (addr_i),
    .io_sel_i (io_sel_i),
    .rd_n_i   (rd_n_i),
    .wr_n_i   (wr_n_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o),
    .csel_o   (csel_o)
);

// File: tb/mirror_memmap_bench.sv
// Bench: scoreboard bench for mirror_memmap. Driver tasks push expected read
// results into a queue; a monitor at the falling edge pops and compares them.
module mirror_memmap_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic       expv;
        logic [7:0] expd;
        logic [1:0] expcs;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        io_sel = 1'b0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        rvalid;
    logic [1:0]  csel;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    exp_t sb [$];

    mirror_memmap u_mirror_memmap (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (addr),
        .io_sel_i (io_sel),
        .rd_n_i   (rd_n),
        .wr_n_i   (wr_n),
        .wdata_i  (wdata),
        .rdata_o  (rdata),
        .rvalid_o (rvalid),
        .csel_o   (csel)
    );

    // free-running clock
    always #(CLK_PERIOD/2) clk = ~clk;

    // expected decode per the requirements: bit0 at 10001b, bit1 at 00100b
    function automatic logic [1:0] exp_cs(input logic [15:0] a, input logic io);
        if (io) return 2'b00;
        if (a[15:11] == 5'b10001) return 2'b01;
        if (a[15:11] == 5'b00100) return 2'b10;
        return 2'b00;
    endfunction

    // one write cycle; the store happens at the second rising edge
    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic io);
        @(posedge clk); #1;
        addr = a; wdata = d; io_sel = io; wr_n = 1'b0; rd_n = 1'b1;
        @(posedge clk); #1;
        wr_n = 1'b1; io_sel = 1'b0;
    endtask

    // one observation cycle; the expected result is queued for the monitor
    task automatic rd(input logic [15:0] a, input logic strobe, input logic io,
                      input logic expv, input logic [7:0] expd, input string tag);
        exp_t e;
        @(posedge clk); #1;
        addr = a; io_sel = io; rd_n = !strobe; wr_n = 1'b1;
        e.expv = expv; e.expd = expd; e.expcs = exp_cs(a, io); e.tag = tag;
        sb.push_back(e);
        @(posedge clk); #1;
        rd_n = 1'b1; io_sel = 1'b0;
    endtask

    // monitor: compare the design outputs mid-cycle against the queued item
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_tests++;
            if (rvalid !== e.expv || rdata !== e.expd) begin
                n_fail++;
                $display("FAIL %s addr=%h: valid=%b data=%h expected valid=%b data=%h",
                         e.tag, addr, rvalid, rdata, e.expv, e.expd);
            end
            n_tests++;
            if (csel !== e.expcs) begin
                n_fail++;
                $display("FAIL R8 addr=%h: csel=%b expected %b", addr, csel, e.expcs);
            end
        end
    end

    // watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // stimulus
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset/idle state: decode visible, nothing valid without a strobe (R5)
        rd(16'h2000, 1'b0, 1'b0, 1'b0, 8'h00, "R5 idle no strobe");
        rd(16'h4000, 1'b0, 1'b0, 1'b0, 8'h00, "R7 idle unmapped");

        // R9: a write during reset does not disturb stored data
        wr(16'h2010, 8'h11, 1'b0);
        @(posedge clk); #1 rst_n = 1'b0;
        wr(16'h2010, 8'hEE, 1'b0);
        @(posedge clk); #1 rst_n = 1'b1;
        rd(16'h2010, 1'b1, 1'b0, 1'b1, 8'h11, "R9 write in reset ignored");

        // R1/R3: 2 KB array across its window with distinct indexes
        wr(16'h8800, 8'hA1, 1'b0);
        wr(16'h8FFF, 8'hB2, 1'b0);
        wr(16'h8C35, 8'hC3, 1'b0);
        wr(16'h8900, 8'hD4, 1'b0);
        rd(16'h8800, 1'b1, 1'b0, 1'b1, 8'hA1, "R1 low edge");
        rd(16'h8FFF, 1'b1, 1'b0, 1'b1, 8'hB2, "R1 high edge");
        rd(16'h8C35, 1'b1, 1'b0, 1'b1, 8'hC3, "R3 mid index");
        rd(16'h8900, 1'b1, 1'b0, 1'b1, 8'hD4, "R3 index A8 distinct");

        // R7: neighbouring windows decode to nothing and do not alias
        rd(16'h87FF, 1'b1, 1'b0, 1'b0, 8'h00, "R7 below 2K window");
        rd(16'h9000, 1'b1, 1'b0, 1'b0, 8'h00, "R7 above 2K window");
        wr(16'h0800, 8'h5A, 1'b0);
        wr(16'h0FFF, 8'h5B, 1'b0);
        wr(16'h8000, 8'h5C, 1'b0);
        wr(16'h9FFF, 8'h5D, 1'b0);
        wr(16'h0C35, 8'h5E, 1'b0);
        rd(16'h8800, 1'b1, 1'b0, 1'b1, 8'hA1, "R7 no alias 0800h/8000h");
        rd(16'h8FFF, 1'b1, 1'b0, 1'b1, 8'hB2, "R7 no alias 0FFFh/9FFFh");
        rd(16'h8C35, 1'b1, 1'b0, 1'b1, 8'hC3, "R7 no alias 0C35h");

        // R2/R4: write through a mirror, read back through primary and others
        wr(16'h2342, 8'h3C, 1'b0);
        rd(16'h2042, 1'b1, 1'b0, 1'b1, 8'h3C, "R4 primary readback");
        rd(16'h2742, 1'b1, 1'b0, 1'b1, 8'h3C, "R4 top mirror");
        rd(16'h2142, 1'b1, 1'b0, 1'b1, 8'h3C, "R2 mirror 2100h");
        wr(16'h27FF, 8'h99, 1'b0);
        rd(16'h20FF, 1'b1, 1'b0, 1'b1, 8'h99, "R4 last byte mirror");
        wr(16'h2800, 8'h77, 1'b0);
        rd(16'h2800, 1'b1, 1'b0, 1'b0, 8'h00, "R7 2800h unmapped");
        wr(16'h2000, 8'h01, 1'b0);
        rd(16'h2400, 1'b1, 1'b0, 1'b1, 8'h01, "R2 mirror 2400h");

        // R6: I/O cycles neither select, return data, nor write
        wr(16'h2042, 8'hFF, 1'b1);
        wr(16'h8C35, 8'hFF, 1'b1);
        rd(16'h2042, 1'b1, 1'b1, 1'b0, 8'h00, "R6 io read silent");
        rd(16'h2042, 1'b1, 1'b0, 1'b1, 8'h3C, "R6 io write ignored small");
        rd(16'h8C35, 1'b1, 1'b0, 1'b1, 8'hC3, "R6 io write ignored big");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule